// File: doc/BRIEF.md
# Signed Multiply Execution Unit

This unit performs two's-complement integer multiplication for a processor datapath. A single start pulse launches an operation. Each operation has an operand size of 8, 16 or 32 bits and one of three forms. The **accumulator form** multiplies an implied accumulator (`opa`) by a source (`opb`) and returns the complete double-width product. The **destination form** multiplies the destination value (`opa`) by a source (`opb`) and keeps only a result of operand width. The **immediate form** multiplies a source (`opb`) by a sign-extended immediate and also keeps only a result of operand width.

The product is formed by a multicycle shift-and-add over operand magnitudes, four multiplier bits per step, and the sign is fixed up at the end. When the result is ready the unit raises `done` for one cycle. The result and the carry/overflow flags then hold until the next operation completes. Each flag pair is set when the full product cannot be represented in the lower half. Sign, zero, half-carry and parity carry no defined meaning after this operation, so the unit drives them low and marks them invalid.

The control state machine has five states:
- `ST_IDLE` goes to `ST_PREP` on an accepted start.
- `ST_PREP` loads the operand magnitudes and goes to `ST_ITER`.
- `ST_ITER` runs eight shift-add steps. On the last step it goes to `ST_STALL` for the long-latency cases and to `ST_FIX` otherwise.
- `ST_STALL` goes to `ST_FIX`.
- `ST_FIX` registers the result and flags, pulses `done` and goes back to `ST_IDLE`.

Top module: `smul_unit`

## Requirements
- R1: In the accumulator form (`op_form`=0), the full signed product is returned untruncated. For size 8 (`op_size`=0), `res_lo[15:0]` holds the 16-bit product and `res_hi` is 0. For size 16 (`op_size`=1), `res_hi[15:0]` holds the upper and `res_lo[15:0]` the lower 16 bits, and the unused upper bits are 0. For size 32 (`op_size`=2), `res_hi` holds product bits 63:32 and `res_lo` bits 31:0. Operand bits above the selected size are ignored.
- R2: In the destination form (`op_form`=1), `res_lo` holds the signed product `opa`×`opb` truncated to the operand size and zero-filled above it, and `res_hi` is 0.
- R3: In the immediate form (`op_form`=2), `opb` is multiplied by the immediate, and the result is truncated exactly as in R2. With `imm_byte`=1 the immediate is `imm[7:0]` sign-extended. With `imm_byte`=0 it is `imm` taken at the operand size.
- R4: `carry_flag` and `ovf_flag` are always equal. They are 1 exactly when the double-width product differs from the sign extension of its lower half.
- R5: `sign_flag`, `zero_flag`, `half_flag`, `parity_flag` and `aux_flags_valid` are 0 at every completion.
- R6: `done` appears 11 clock edges after the edge that accepts start for accumulator-form sizes 8 and 16, and 10 edges after it for every other accepted operation.
- R7: `done` is a single-cycle pulse. `busy` is high from acceptance until `done`. Results and flags change only in the cycle `done` rises.
- R8: A start while `busy` is high is ignored. The running operation completes with its own operands, and no extra `done` follows.
- R9: A start with size 8 in the destination or immediate form, with `op_size`=3, or with `op_form`=3 is rejected. `busy` stays low and no `done` follows.
- R10: In the truncated forms, `res_lo` equals the low operand-width bits of the unsigned product of the same bit patterns.
- R11: After reset, `busy`, `done`, the results and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit |
| op_form | input | 2 | 0: accumulator, 1: destination, 2: immediate |
| opa | input | W | Accumulator or destination operand |
| opb | input | W | Source operand |
| imm | input | W | Immediate value |
| imm_byte | input | 1 | Immediate is a sign-extended byte |
| res_hi | output | W | Upper product half (accumulator form) |
| res_lo | output | W | Lower product half or truncated result |
| carry_flag | output | 1 | Significant bits lost or present in upper half |
| ovf_flag | output | 1 | Same condition as carry_flag |
| sign_flag | output | 1 | Undefined flag, driven 0 |
| zero_flag | output | 1 | Undefined flag, driven 0 |
| half_flag | output | 1 | Undefined flag, driven 0 |
| parity_flag | output | 1 | Undefined flag, driven 0 |
| aux_flags_valid | output | 1 | Always 0: the four flags above carry no meaning |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the inputs are driven from reset onward and that `start` is a plain level sampled at each edge; they make no assumption about the operand values. The result-stability property relies on nothing writing the outputs outside `ST_FIX`. The busy-hold property relies on a start during `busy` being harmless, so the stimulus deliberately drives such a start with different operands. The stimulus changes inputs only on falling edges. It includes the most negative value times minus one at each size, zero operands, stray bits above the operand size, and a negative byte immediate used in a 32-bit operation.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        FM_ACC  = 2'd0,
        FM_DST  = 2'd1,
        FM_IMM  = 2'd2,
        FM_NONE = 2'd3
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PREP  = 3'd1,
        ST_ITER  = 3'd2,
        ST_STALL = 3'd3,
        ST_FIX   = 3'd4
    } state_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
endpackage

// File: rtl/smul_opsel.sv
// Operand selection: sign-extends per size, picks the multiplicand and
// multiplier for the form, and returns magnitudes plus the product sign.
module smul_opsel
    import smul_pkg::*;
#(
    parameter int W = 32
) (
    input  size_e          size,
    input  form_e          form,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic [W-1:0]   imm_in,
    input  logic           imm_is_byte,
    output logic [W-1:0]   mag_x,
    output logic [W-1:0]   mag_y,
    output logic           neg
);
    logic [W-1:0] a_ext, b_ext, i_ext, x_val, y_val;

    function automatic logic [W-1:0] widen(input logic [W-1:0] v, input size_e s);
        logic [W-1:0] r;
        unique case (s)
            SZ_BYTE: r = {{(W-BYTE_W){v[BYTE_W-1]}}, v[BYTE_W-1:0]};
            SZ_HALF: r = {{(W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

    always_comb begin
        a_ext = widen(a_in, size);
        b_ext = widen(b_in, size);
        i_ext = imm_is_byte ? {{(W-BYTE_W){imm_in[BYTE_W-1]}}, imm_in[BYTE_W-1:0]}
                            : widen(imm_in, size);
        if (form == FM_IMM) begin
            x_val = b_ext;
            y_val = i_ext;
        end else begin
            x_val = a_ext;
            y_val = b_ext;
        end
        mag_x = x_val[W-1] ? (~x_val + 1'b1) : x_val;
        mag_y = y_val[W-1] ? (~y_val + 1'b1) : y_val;
        neg   = x_val[W-1] ^ y_val[W-1];
    end
endmodule

// File: rtl/smul_core.sv
// Iterative unsigned shift-and-add, DIGIT multiplier bits per step.
module smul_core #(
    parameter int W     = 32,
    parameter int DIGIT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mag_x,
    input  logic [W-1:0]   mag_y,
    output logic [2*W-1:0] acc
);
    localparam int PW = 2 * W;

    logic [PW-1:0] xs_q;
    logic [W-1:0]  ys_q;
    logic [PW-1:0] partial;

    always_comb begin
        partial = '0;
        for (int k = 0; k < DIGIT; k++) begin
            if (ys_q[k]) partial = partial + (xs_q << k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            xs_q <= '0;
            ys_q <= '0;
        end else if (load) begin
            acc  <= '0;
            xs_q <= {{W{1'b0}}, mag_x};
            ys_q <= mag_y;
        end else if (step) begin
            acc  <= acc + partial;
            xs_q <= xs_q << DIGIT;
            ys_q <= ys_q >> DIGIT;
        end
    end
endmodule

// File: rtl/smul_pack.sv
// Sign fix-up, per-size result placement and the fit test.
module smul_pack
    import smul_pkg::*;
#(
    parameter int W = 32
) (
    input  size_e          size,
    input  form_e          form,
    input  logic           neg,
    input  logic [2*W-1:0] acc,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo,
    output logic           lost
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic          full_form;

    always_comb begin
        prod      = neg ? (~acc + 1'b1) : acc;
        full_form = (form == FM_ACC);
        hi        = '0;
        lo        = '0;
        unique case (size)
            SZ_BYTE: begin
                lost = prod[2*BYTE_W-1:BYTE_W] != {BYTE_W{prod[BYTE_W-1]}};
                if (full_form) lo = {{(W-2*BYTE_W){1'b0}}, prod[2*BYTE_W-1:0]};
                else           lo = {{(W-BYTE_W){1'b0}}, prod[BYTE_W-1:0]};
            end
            SZ_HALF: begin
                lost = prod[2*HALF_W-1:HALF_W] != {HALF_W{prod[HALF_W-1]}};
                lo   = {{(W-HALF_W){1'b0}}, prod[HALF_W-1:0]};
                if (full_form) hi = {{(W-HALF_W){1'b0}}, prod[2*HALF_W-1:HALF_W]};
            end
            default: begin
                lost = prod[PW-1:W] != {W{prod[W-1]}};
                lo   = prod[W-1:0];
                if (full_form) hi = prod[PW-1:W];
            end
        endcase
    end
endmodule

// File: rtl/smul_unit.sv
module smul_unit
    import smul_pkg::*;
#(
    parameter int W     = 32,
    parameter int DIGIT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op_size,
    input  logic [1:0]   op_form,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] imm,
    input  logic         imm_byte,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         carry_flag,
    output logic         ovf_flag,
    output logic         sign_flag,
    output logic         zero_flag,
    output logic         half_flag,
    output logic         parity_flag,
    output logic         aux_flags_valid,
    output logic         busy,
    output logic         done
);
    localparam int ITERS = W / DIGIT;
    localparam int CW    = $clog2(ITERS + 1);

    state_e         state_q, state_d;
    logic [CW-1:0]  cnt_q;
    size_e          size_in, size_q;
    form_e          form_in, form_q;
    logic [W-1:0]   a_q, b_q, imm_q;
    logic           immb_q, long_q;
    logic           legal, accept;
    logic [W-1:0]   mag_x, mag_y, pk_hi, pk_lo;
    logic           neg, pk_lost;
    logic [2*W-1:0] acc;

    assign size_in = size_e'(op_size);
    assign form_in = form_e'(op_form);
    assign legal   = (size_in != SZ_NONE) && (form_in != FM_NONE) &&
                     !(size_in == SZ_BYTE && form_in != FM_ACC);
    assign accept  = start && (state_q == ST_IDLE) && legal;
    assign busy    = (state_q != ST_IDLE);

    // Flags without defined meaning for this operation
    assign sign_flag       = 1'b0;
    assign zero_flag       = 1'b0;
    assign half_flag       = 1'b0;
    assign parity_flag     = 1'b0;
    assign aux_flags_valid = 1'b0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_PREP;
            ST_PREP:  state_d = ST_ITER;
            ST_ITER:  if (cnt_q == '0) state_d = long_q ? ST_STALL : ST_FIX;
            ST_STALL: state_d = ST_FIX;
            ST_FIX:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Step counter and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            size_q <= SZ_WORD;
            form_q <= FM_ACC;
            a_q    <= '0;
            b_q    <= '0;
            imm_q  <= '0;
            immb_q <= 1'b0;
            long_q <= 1'b0;
        end else begin
            if (accept) begin
                size_q <= size_in;
                form_q <= form_in;
                a_q    <= opa;
                b_q    <= opb;
                imm_q  <= imm;
                immb_q <= imm_byte;
                long_q <= (form_in == FM_ACC) && (size_in != SZ_WORD);
            end
            if (state_q == ST_PREP)
                cnt_q <= CW'(ITERS - 1);
            else if (state_q == ST_ITER && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    smul_opsel #(.W(W)) u_opsel (
        .size        (size_q),
        .form        (form_q),
        .a_in        (a_q),
        .b_in        (b_q),
        .imm_in      (imm_q),
        .imm_is_byte (immb_q),
        .mag_x       (mag_x),
        .mag_y       (mag_y),
        .neg         (neg)
    );

    smul_core #(.W(W), .DIGIT(DIGIT)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_PREP),
        .step  (state_q == ST_ITER),
        .mag_x (mag_x),
        .mag_y (mag_y),
        .acc   (acc)
    );

    smul_pack #(.W(W)) u_pack (
        .size (size_q),
        .form (form_q),
        .neg  (neg),
        .acc  (acc),
        .hi   (pk_hi),
        .lo   (pk_lo),
        .lost (pk_lost)
    );

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            res_hi     <= '0;
            res_lo     <= '0;
            carry_flag <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            done <= (state_q == ST_FIX);
            if (state_q == ST_FIX) begin
                res_hi     <= pk_hi;
                res_lo     <= pk_lo;
                carry_flag <= pk_lost;
                ovf_flag   <= pk_lost;
            end
        end
    end

    // Assertions
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(res_lo) && $stable(res_hi) && $stable(carry_flag)) |-> done);

    assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_flags_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (carry_flag == ovf_flag));

    assert_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && form_q != FM_ACC) |-> (res_hi == '0));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_FIX) |=> busy);

    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_size == 2'd0 && op_form != 2'd0) |=> !busy);
endmodule

// File: tb/smul_unit_tb.sv
module smul_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_size = '0, op_form = '0;
    logic [31:0] opa = '0, opb = '0, imm = '0;
    logic        imm_byte = 1'b0;
    logic [31:0] res_hi, res_lo;
    logic        carry_flag, ovf_flag, sign_flag, zero_flag, half_flag, parity_flag;
    logic        aux_flags_valid, busy, done;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        logic        lost;
        longint      at;
        logic        trunc;
        logic [31:0] ulo;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    smul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size), .op_form(op_form),
        .opa(opa), .opb(opb), .imm(imm), .imm_byte(imm_byte),
        .res_hi(res_hi), .res_lo(res_lo), .carry_flag(carry_flag), .ovf_flag(ovf_flag),
        .sign_flag(sign_flag), .zero_flag(zero_flag), .half_flag(half_flag),
        .parity_flag(parity_flag), .aux_flags_valid(aux_flags_valid),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic longint sx(input logic [31:0] v, input int n);
        logic [63:0] t;
        t = {32'b0, v} << (64 - n);
        return $signed(t) >>> (64 - n);
    endfunction

    function automatic item_t model(input logic [1:0] sz, input logic [1:0] fm,
                                    input logic [31:0] a, input logic [31:0] b,
                                    input logic [31:0] im, input logic ib);
        item_t  e;
        int     n;
        longint x, y, full, lim;
        logic [63:0] f, mask, up;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        x    = (fm == 2'd2) ? sx(b, n) : sx(a, n);
        y    = (fm == 2'd2) ? (ib ? sx(im, 8) : sx(im, n)) : sx(b, n);
        full = x * y;
        f    = full;
        lim  = longint'(1) << (n - 1);
        e.lost  = !(full >= -lim && full < lim);
        e.trunc = (fm != 2'd0);
        e.hi = '0;
        e.lo = '0;
        mask = (64'd1 << n) - 64'd1;
        if (fm == 2'd0) begin
            if (n == 8)       e.lo = {16'b0, f[15:0]};
            else if (n == 16) begin e.hi = {16'b0, f[31:16]}; e.lo = {16'b0, f[15:0]}; end
            else              begin e.hi = f[63:32]; e.lo = f[31:0]; end
        end else begin
            e.lo = 32'(f & mask);
        end
        up    = (64'(x) & mask) * (64'(y) & mask);
        e.ulo = 32'(up & mask);
        e.at  = cyc + 1 + ((fm == 2'd0 && n < 32) ? 11 : 10);
        return e;
    endfunction

    // Monitor: pops and compares at every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8/R9", "unexpected done", 64'd1, 64'd0);
            end else begin
                item_t e;
                e = sb_q.pop_front();
                chk(res_hi == e.hi, "R1/R2", "res_hi", 64'(res_hi), 64'(e.hi));
                chk(res_lo == e.lo, "R1/R2/R3", "res_lo", 64'(res_lo), 64'(e.lo));
                chk(carry_flag == e.lost, "R4", "carry_flag", 64'(carry_flag), 64'(e.lost));
                chk(ovf_flag == e.lost, "R4", "ovf_flag", 64'(ovf_flag), 64'(e.lost));
                chk(cyc == e.at, "R6", "done cycle", 64'(cyc), 64'(e.at));
                chk({sign_flag, zero_flag, half_flag, parity_flag, aux_flags_valid} == 5'b0,
                    "R5", "undefined flags", 64'({sign_flag, zero_flag, half_flag,
                    parity_flag, aux_flags_valid}), 64'd0);
                if (e.trunc)
                    chk(res_lo == e.ulo, "R10", "unsigned low half", 64'(res_lo), 64'(e.ulo));
            end
        end
    end

    task automatic launch(input logic [1:0] sz, input logic [1:0] fm, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] im, input logic ib);
        @(negedge clk);
        op_size = sz; op_form = fm; opa = a; opb = b; imm = im; imm_byte = ib;
        start = 1'b1;
        sb_q.push_back(model(sz, fm, a, b, im, ib));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] sz, input logic [1:0] fm, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] im, input logic ib);
        launch(sz, fm, a, b, im, ib);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 64'(cyc), 64'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done, "R11", "busy/done after reset", 64'({busy, done}), 64'd0);
        chk(res_hi == 0 && res_lo == 0, "R11", "results after reset", {res_hi, res_lo}, 64'd0);
        chk(!carry_flag && !ovf_flag, "R11", "flags after reset", 64'({carry_flag, ovf_flag}), 64'd0);

        // R1 accumulator form, all sizes
        run_op(2'd0, 2'd0, 32'h7F, 32'h80, 0, 0);
        run_op(2'd0, 2'd0, 32'h80, 32'hFF, 0, 0);              // -128 * -1
        run_op(2'd0, 2'd0, 32'hABCDEF03, 32'h123456FE, 0, 0);  // upper bits ignored, 3*-2
        run_op(2'd1, 2'd0, 32'h8000, 32'hFFFF, 0, 0);
        run_op(2'd1, 2'd0, 32'h04D2, 32'hFFFB, 0, 0);
        run_op(2'd2, 2'd0, 32'h80000000, 32'hFFFFFFFF, 0, 0);
        run_op(2'd2, 2'd0, 32'h12345678, 32'h9ABCDEF0, 0, 0);
        run_op(2'd2, 2'd0, 32'h0, 32'hDEADBEEF, 0, 0);         // zero operand
        // R2 destination form
        run_op(2'd1, 2'd1, 32'd300, 32'd300, 0, 0);
        run_op(2'd1, 2'd1, 32'hFFFE, 32'd3, 0, 0);
        run_op(2'd1, 2'd1, 32'h8000, 32'hFFFF, 0, 0);
        run_op(2'd2, 2'd1, 32'h80000000, 32'hFFFFFFFF, 0, 0);
        run_op(2'd2, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0);
        run_op(2'd2, 2'd1, 32'h00010000, 32'h00010000, 0, 0);
        // R3 immediate form
        run_op(2'd2, 2'd2, 0, 32'd1000, 32'h000000F6, 1);      // negative byte imm
        run_op(2'd1, 2'd2, 0, 32'h1234, 32'h00008000, 0);
        run_op(2'd2, 2'd2, 0, 32'h7FFFFFFF, 32'h00000002, 0);
        run_op(2'd1, 2'd2, 0, 32'h0000, 32'h000000FF, 1);      // zero source

        // R7 results hold after done
        repeat (5) @(negedge clk);
        chk(res_lo == 32'h0 && !done, "R7", "result held idle", 64'(res_lo), 64'd0);

        // R8 start while busy ignored
        launch(2'd2, 2'd1, 32'd7, 32'd9, 0, 0);
        repeat (3) @(negedge clk);
        chk(busy, "R8", "busy mid-operation", 64'(busy), 64'd1);
        op_size = 2'd0; op_form = 2'd0; opa = 32'h55; opb = 32'h66; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (15) @(negedge clk);

        // R9 illegal combinations rejected
        @(negedge clk);
        op_size = 2'd0; op_form = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R9", "byte dest form busy", 64'(busy), 64'd0);
        op_size = 2'd1; op_form = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R9", "form 3 busy", 64'(busy), 64'd0);
        op_size = 2'd3; op_form = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R9", "size 3 busy", 64'(busy), 64'd0);
        repeat (15) @(negedge clk);
        chk(res_lo == 32'd63, "R9", "result unchanged", 64'(res_lo), 64'd63);

        chk(sb_q.size() == 0, "R6", "pending completions", 64'(sb_q.size()), 64'd0);
        finish_run();
    end
endmodule